// File: doc/BRIEF.md
# Root Hub Downstream Port Status Controller

This block holds the status and control word of one downstream port of a USB host root hub. Software reads a single word that reports connection, enable, suspend, reset, power and low-speed state, plus sticky change flags. A write to the same word is a set of command strobes rather than a data store. Each written 1 asks for one action, and that action depends on the bit position. Written 0s do nothing.

Four things drive the port state: software commands, the attach and low-speed levels from the line monitor, a strap that marks a soldered-down device, and a completion pulse from the resume sequencer. A command that needs an attached device is refused when no device is present. The refused command raises the connect-change flag so the driver learns the port is empty. Bus reset signaling is timed inside the block by a cycle counter. At the end of the reset the port enables itself and raises a reset-change flag.

Top module: `root_port_status`

## Requirements
- R1: After reset, every read bit is 0 and both port_reset_o and suspend_o are low.
- R2: Read bit 0 (connected) follows attach_i OR fixed_dev_i one clock later. Any change of that value sets bit 16 (connect change). A detach also clears enable (bit 1), suspend (bit 2) and any running bus reset (bit 4) in the same clock. If the port was enabled, the detach sets bit 17 (enable change).
- R3: Writing 1 to bit 0 clears enable. Writing 1 to bit 1 sets enable only while connected, and the clear wins if both are written. Writing 1 to bit 1 while disconnected leaves enable at 0 and sets bit 16.
- R4: Writing 1 to bit 2 sets suspend (read bit 2, suspend_o) while connected. While disconnected, suspend stays 0 and bit 16 is set instead.
- R5: Writing 1 to bit 4 while connected starts bus reset. Read bit 4 and port_reset_o then stay high for exactly RESET_CYCLES clocks. Writing bit 4 again while reset runs has no effect. Writing bit 4 while disconnected sets bit 16 and starts no reset.
- R6: When bus reset completes, enable is set, suspend is cleared and bit 20 (reset change) is set.
- R7: A resume_done_i pulse while suspended clears suspend and sets bit 18 (suspend change). A resume_done_i pulse while not suspended changes nothing.
- R8: Writing 1 to bit 8 turns port power on and writing 1 to bit 9 turns it off. If both are written, power goes off. Read bit 8 shows power.
- R9: Read bit 9 shows low_speed_i (registered) while connected, and 0 while disconnected.
- R10: Writing 1 to bit 16, 17, 18 or 20 clears that change flag. If hardware sets the same flag in the same clock, the flag stays set. Writing 0 leaves the flag unchanged.
- R11: With fixed_dev_i high, read bit 0 is 1 whatever attach_i does.
- R12: All read bits other than 0, 1, 2, 4, 8, 9, 16, 17, 18 and 20 read 0. port_reset_o equals read bit 4 and suspend_o equals read bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the command word |
| wdata_i | input | DW | Command word, one action per bit set |
| attach_i | input | 1 | Device present level from line monitor |
| low_speed_i | input | 1 | Attached device is low speed |
| fixed_dev_i | input | 1 | Strap: non-removable device fitted |
| resume_done_i | input | 1 | Pulse: resume sequence finished |
| rdata_o | output | DW | Status word |
| port_reset_o | output | 1 | Drive bus reset on the port |
| suspend_o | output | 1 | Hold the port in suspend |

## Verification
The assertions check several rules on every clock. Enable and suspend never stand while disconnected. A running reset holds until its count expires. Reset completion leaves the port enabled and not suspended. A clear command empties a change flag unless hardware sets it in the same clock. Power-off commands take effect. Other behaviour can only be seen through the bench's scenarios: the exact reset length, the refusal of commands on an empty port, and the ordering when set and clear commands land together. The same holds for detach during a reset, the strap override and low-speed masking. The bench compares the whole status word with a reference model on every clock.

// File: rtl/root_port_pkg.sv
package root_port_pkg;
  localparam int unsigned B_CONN   = 0;
  localparam int unsigned B_EN     = 1;
  localparam int unsigned B_SUSP   = 2;
  localparam int unsigned B_RST    = 4;
  localparam int unsigned B_PWR    = 8;
  localparam int unsigned B_LS     = 9;
  localparam int unsigned B_CONN_C = 16;
  localparam int unsigned B_EN_C   = 17;
  localparam int unsigned B_SUSP_C = 18;
  localparam int unsigned B_RST_C  = 20;

  localparam int unsigned NFLAGS = 4;
  localparam int unsigned F_CONN = 0;
  localparam int unsigned F_EN   = 1;
  localparam int unsigned F_SUSP = 2;
  localparam int unsigned F_RST  = 3;

  typedef struct packed {
    logic clr_en;
    logic set_en;
    logic set_susp;
    logic set_rst;
    logic set_pwr;
    logic clr_pwr;
    logic [NFLAGS-1:0] clr_flag;
  } port_cmd_t;

  function automatic port_cmd_t decode_cmd(input logic wr, input logic [31:0] wd);
    port_cmd_t c;
    c.clr_en   = wr & wd[B_CONN];
    c.set_en   = wr & wd[B_EN];
    c.set_susp = wr & wd[B_SUSP];
    c.set_rst  = wr & wd[B_RST];
    c.set_pwr  = wr & wd[B_PWR];
    c.clr_pwr  = wr & wd[B_LS];
    c.clr_flag[F_CONN] = wr & wd[B_CONN_C];
    c.clr_flag[F_EN]   = wr & wd[B_EN_C];
    c.clr_flag[F_SUSP] = wr & wd[B_SUSP_C];
    c.clr_flag[F_RST]  = wr & wd[B_RST_C];
    return c;
  endfunction
endpackage

// File: rtl/port_conn_track.sv
module port_conn_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic attach_i,
  input  logic fixed_dev_i,
  input  logic low_speed_i,
  output logic conn_o,
  output logic ls_o,
  output logic attach_ev_o,
  output logic detach_ev_o
);
  logic conn_d, conn_q, ls_q;

  assign conn_d      = attach_i | fixed_dev_i;
  assign attach_ev_o = conn_d & ~conn_q;
  assign detach_ev_o = ~conn_d & conn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= 1'b0;
      ls_q   <= 1'b0;
    end else begin
      conn_q <= conn_d;
      ls_q   <= low_speed_i;
    end
  end

  assign conn_o = conn_q;
  assign ls_o   = ls_q & conn_q;

  a_r11_strap_connects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fixed_dev_i |=> conn_o);
  a_r2_detach_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detach_ev_o |=> !conn_o);
endmodule

// File: rtl/port_rst_timer.sv
module port_rst_timer #(
  parameter int unsigned CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  assign done_o   = active_q & (cnt_q == '0) & ~abort_i;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= LOAD;
      end
    end else if (abort_i || cnt_q == '0) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q <= LOAD));
  a_r5_holds_until_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q != '0 && !abort_i) |=> active_q);
  a_r5_ends_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !active_q);
endmodule

// File: rtl/port_change_flags.sv
module port_change_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (set_i[i])  flag_q[i] <= 1'b1;   // hardware event beats software clear
      else if (clr_i[i])  flag_q[i] <= 1'b0;
    end

    a_r10_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    a_r10_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_o[i]);
    a_r10_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !clr_i[i]) |=> $stable(flag_o[i]));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/port_ctrl_core.sv
module port_ctrl_core
  import root_port_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  port_cmd_t cmd_i,
  input  logic      conn_i,
  input  logic      detach_ev_i,
  input  logic      resume_done_i,
  input  logic      rst_active_i,
  input  logic      rst_done_i,
  output logic      en_o,
  output logic      susp_o,
  output logic      pwr_o,
  output logic      rst_start_o,
  output logic      refused_o,
  output logic      en_chg_o,
  output logic      susp_chg_o
);
  logic en_q, susp_q, pwr_q;
  logic en_d, susp_d, pwr_d;

  assign rst_start_o = cmd_i.set_rst & conn_i & ~rst_active_i & ~detach_ev_i;
  // commands needing a device, issued to an empty port
  assign refused_o   = ~conn_i & (cmd_i.set_en | cmd_i.set_susp | cmd_i.set_rst);
  assign en_chg_o    = detach_ev_i & en_q;
  assign susp_chg_o  = resume_done_i & susp_q & ~detach_ev_i;

  always_comb begin
    en_d = en_q;
    if (detach_ev_i)                 en_d = 1'b0;
    else if (rst_done_i)             en_d = 1'b1;
    else if (cmd_i.clr_en)           en_d = 1'b0;
    else if (cmd_i.set_en && conn_i) en_d = 1'b1;

    susp_d = susp_q;
    if (detach_ev_i || rst_done_i)     susp_d = 1'b0;
    else if (resume_done_i && susp_q)  susp_d = 1'b0;
    else if (cmd_i.set_susp && conn_i) susp_d = 1'b1;

    pwr_d = pwr_q;
    if (cmd_i.clr_pwr)      pwr_d = 1'b0;
    else if (cmd_i.set_pwr) pwr_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      pwr_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      susp_q <= susp_d;
      pwr_q  <= pwr_d;
    end
  end

  assign en_o   = en_q;
  assign susp_o = susp_q;
  assign pwr_o  = pwr_q;

  a_r2_no_enable_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conn_i |-> !en_q);
  a_r4_no_suspend_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conn_i |-> !susp_q);
  a_r6_done_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_done_i |=> (en_q && !susp_q));
  a_r7_resume_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_done_i && susp_q) |=> !susp_q);
  a_r8_power_off_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.clr_pwr |=> !pwr_q);
  a_r3_clear_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.clr_en && !rst_done_i) |=> !en_q);
endmodule

// File: rtl/root_port_status.sv
module root_port_status
  import root_port_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned RESET_CYCLES = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          attach_i,
  input  logic          low_speed_i,
  input  logic          fixed_dev_i,
  input  logic          resume_done_i,
  output logic [DW-1:0] rdata_o,
  output logic          port_reset_o,
  output logic          suspend_o
);
  localparam int unsigned CW = (DW < 32) ? DW : 32;

  logic [31:0]       wd32;
  port_cmd_t         cmd;
  logic              conn, ls, att_ev, det_ev;
  logic              en, susp, pwr, rst_start, refused, en_chg, susp_chg;
  logic              rst_active, rst_done;
  logic [NFLAGS-1:0] flag_set, flags;
  logic              unused_wdata;

  always_comb begin
    wd32 = '0;
    wd32[CW-1:0] = wdata_i[CW-1:0];
  end
  assign unused_wdata = ^wdata_i;
  assign cmd = decode_cmd(wr_en_i, wd32);

  port_conn_track u_conn (
    .clk_i, .rst_ni, .attach_i, .fixed_dev_i, .low_speed_i,
    .conn_o(conn), .ls_o(ls), .attach_ev_o(att_ev), .detach_ev_o(det_ev)
  );

  port_rst_timer #(.CYCLES(RESET_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(rst_start), .abort_i(det_ev),
    .active_o(rst_active), .done_o(rst_done)
  );

  port_ctrl_core u_core (
    .clk_i, .rst_ni, .cmd_i(cmd), .conn_i(conn), .detach_ev_i(det_ev),
    .resume_done_i, .rst_active_i(rst_active), .rst_done_i(rst_done),
    .en_o(en), .susp_o(susp), .pwr_o(pwr), .rst_start_o(rst_start),
    .refused_o(refused), .en_chg_o(en_chg), .susp_chg_o(susp_chg)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[F_CONN] = att_ev | det_ev | refused;
    flag_set[F_EN]   = en_chg;
    flag_set[F_SUSP] = susp_chg;
    flag_set[F_RST]  = rst_done;
  end

  port_change_flags #(.N(NFLAGS)) u_flags (
    .clk_i, .rst_ni, .set_i(flag_set), .clr_i(cmd.clr_flag), .flag_o(flags)
  );

  always_comb begin
    rdata_o           = '0;
    rdata_o[B_CONN]   = conn;
    rdata_o[B_EN]     = en;
    rdata_o[B_SUSP]   = susp;
    rdata_o[B_RST]    = rst_active;
    rdata_o[B_PWR]    = pwr;
    rdata_o[B_LS]     = ls;
    rdata_o[B_CONN_C] = flags[F_CONN];
    rdata_o[B_EN_C]   = flags[F_EN];
    rdata_o[B_SUSP_C] = flags[F_SUSP];
    rdata_o[B_RST_C]  = flags[F_RST];
  end

  assign port_reset_o = rst_active;
  assign suspend_o    = susp;

  initial begin
    a_r12_width_fits: assert (DW > B_RST_C);
    a_r5_len_nonzero: assert (RESET_CYCLES >= 1);
  end

  a_r5_refused_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.set_rst && !conn && !rst_active) |=> !port_reset_o);
  a_r6_done_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_done |=> (rdata_o[B_RST_C] && !port_reset_o));
  a_r2_detach_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_ev |=> (rdata_o[B_CONN_C] && !port_reset_o && !suspend_o));
endmodule

// File: tb/sim_root_port_status.sv
module sim_root_port_status;
  localparam int unsigned RC = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        attach_i = 1'b0;
  logic        low_speed_i = 1'b0;
  logic        fixed_dev_i = 1'b0;
  logic        resume_done_i = 1'b0;
  logic [31:0] rdata_o;
  logic        port_reset_o, suspend_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  root_port_status #(.DW(32), .RESET_CYCLES(RC)) u0 (.*);

  // reference state
  bit m_conn, m_ls, m_en, m_susp, m_pwr, m_rst;
  int m_cnt;
  bit m_cc, m_ec, m_sc, m_rc;

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[0] = m_conn; w[1] = m_en; w[2] = m_susp; w[4] = m_rst;
    w[8] = m_pwr;  w[9] = m_conn & m_ls;
    w[16] = m_cc; w[17] = m_ec; w[18] = m_sc; w[20] = m_rc;
    return w;
  endfunction

  task automatic model_step(input bit wr, input logic [31:0] wd, input bit att,
                            input bit ls, input bit strap, input bit res);
    bit cn, ae, de, fin, go, c0, c1, c2, c4, c8, c9;
    cn = att | strap;
    ae = cn & !m_conn;
    de = !cn & m_conn;
    c0 = wr & wd[0]; c1 = wr & wd[1]; c2 = wr & wd[2]; c4 = wr & wd[4];
    c8 = wr & wd[8]; c9 = wr & wd[9];
    fin = m_rst && m_cnt == 0 && !de;
    go  = c4 && m_conn && !m_rst && !de;
    // change flags: set beats clear
    m_cc = (ae | de | (!m_conn & (c1 | c2 | c4))) | (m_cc & !(wr & wd[16]));
    m_ec = (de & m_en) | (m_ec & !(wr & wd[17]));
    m_sc = (res & m_susp & !de) | (m_sc & !(wr & wd[18]));
    m_rc = fin | (m_rc & !(wr & wd[20]));
    if (de) m_en = 0; else if (fin) m_en = 1; else if (c0) m_en = 0; else if (c1 && m_conn) m_en = 1;
    if (de || fin) m_susp = 0; else if (res && m_susp) m_susp = 0; else if (c2 && m_conn) m_susp = 1;
    if (c9) m_pwr = 0; else if (c8) m_pwr = 1;
    if (go) begin m_rst = 1; m_cnt = RC - 1; end
    else if (m_rst) begin
      if (de || m_cnt == 0) begin m_rst = 0; m_cnt = 0; end
      else m_cnt = m_cnt - 1;
    end
    m_conn = cn;
    m_ls   = ls;
  endtask

  task automatic check_now(input string tag);
    logic [31:0] e;
    e = exp_word();
    checks++;
    if (rdata_o !== e || port_reset_o !== e[4] || suspend_o !== e[2]) begin
      fails++;
      $display("FAIL %s word=%h rst=%b susp=%b expected word=%h rst=%b susp=%b",
               tag, rdata_o, port_reset_o, suspend_o, e, e[4], e[2]);
    end
  endtask

  // apply inputs for one clock, then check at the following falling edge
  task automatic cyc(input bit wr, input logic [31:0] wd, input bit att, input bit ls,
                     input bit strap, input bit res, input string tag);
    wr_en_i = wr; wdata_i = wd; attach_i = att; low_speed_i = ls;
    fixed_dev_i = strap; resume_done_i = res;
    model_step(wr, wd, att, ls, strap, res);
    @(negedge clk_i);
    check_now(tag);
  endtask

  task automatic idle(input int n, input bit att, input bit ls, input string tag);
    for (int i = 0; i < n; i++) cyc(0, '0, att, ls, 0, 0, tag);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    bit a, l, s;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    {m_conn, m_ls, m_en, m_susp, m_pwr, m_rst, m_cc, m_ec, m_sc, m_rc} = '0;
    m_cnt = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check_now("R1 reset state");

    cyc(1, 32'h2, 0, 0, 0, 0, "R3 set enable while empty");
    cyc(1, 32'h4, 0, 0, 0, 0, "R4 suspend while empty");
    cyc(1, 32'h10, 0, 0, 0, 0, "R5 reset while empty");
    cyc(1, 32'h1_0000, 0, 0, 0, 0, "R10 clear connect change");
    cyc(0, '0, 1, 0, 0, 0, "R2 attach");
    cyc(1, 32'h1_0000, 1, 0, 0, 0, "R10 clear after attach");
    cyc(1, 32'h2, 1, 0, 0, 0, "R3 set enable connected");
    cyc(1, 32'h3, 1, 0, 0, 0, "R3 clear wins");
    cyc(1, 32'h10, 1, 0, 0, 0, "R5 start reset");
    cyc(1, 32'h10, 1, 0, 0, 0, "R5 retrigger ignored");
    idle(RC + 1, 1, 0, "R5 R6 reset run and completion");
    cyc(1, 32'h10_0000, 1, 0, 0, 0, "R10 clear reset change");
    cyc(1, 32'h4, 1, 0, 0, 0, "R4 suspend connected");
    cyc(0, '0, 1, 0, 0, 1, "R7 resume completes");
    cyc(0, '0, 1, 0, 0, 1, "R7 resume ignored when awake");
    cyc(1, 32'h4_0000, 1, 0, 0, 0, "R10 clear suspend change");
    cyc(1, 32'h0, 1, 0, 0, 0, "R10 zero write no effect");
    cyc(1, 32'h100, 1, 0, 0, 0, "R8 power on");
    cyc(1, 32'h300, 1, 0, 0, 0, "R8 off wins");
    cyc(0, '0, 1, 1, 0, 0, "R9 low speed latch");
    cyc(0, '0, 1, 1, 0, 0, "R9 low speed shown");
    cyc(1, 32'h4, 1, 1, 0, 0, "R4 suspend before reset");
    cyc(1, 32'h10, 1, 1, 0, 0, "R6 reset clears suspend");
    idle(RC, 1, 1, "R6 reset completion");
    cyc(1, 32'h10, 1, 1, 0, 0, "R2 start reset then detach");
    cyc(0, '0, 0, 1, 0, 0, "R2 detach aborts reset");
    cyc(0, '0, 0, 1, 0, 0, "R9 low speed masked");
    cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R12 all-ones write");
    cyc(0, '0, 0, 0, 1, 0, "R11 strap connects");
    idle(3, 0, 0, "R11 strap holds");
    cyc(0, '0, 0, 0, 1, 0, "R11 strap with no attach");

    // random phase
    a = 0; l = 0; s = 0;
    for (int i = 0; i < 4000; i++) begin
      bit wr, rs;
      logic [31:0] wd;
      if ($urandom_range(0, 19) == 0) a = ~a;
      if ($urandom_range(0, 29) == 0) l = ~l;
      if ($urandom_range(0, 299) == 0) s = ~s;
      wr = ($urandom_range(0, 2) == 0);
      wd = $urandom & 32'h0017_0317;
      if ($urandom_range(0, 3) == 0) wd = wd | $urandom;
      rs = ($urandom_range(0, 7) == 0);
      cyc(wr, wd, a, l, s, rs, "R2..R12 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule